// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This unit keeps a signed 64-bit accumulator, kept as two 32-bit halves (`acc_hi` above `acc_lo`), and adds a signed product of two operands to it each time it is started. Long mode multiplies the full 32-bit operands. Word mode multiplies only their sign-extended low 16 bits. With saturation disabled the wrapped 64-bit sum is stored. With saturation enabled each mode clamps in its own way. Long mode bounds the high half as a 48-bit accumulator would. Word mode pins the high half to 1 and clamps the low half to the 32-bit signed limits.

Software-visible state is changed through three paths. A clear strobe zeroes both halves. Two load strobes each write one half directly. A start strobe performs one accumulate. The update is applied on the clock edge that samples `start`. A one-cycle `done` pulse marks the cycle in which the new value first appears at the outputs. Decoding operations and fetching operands from memory are left to the surrounding logic.

Top module: `mac_sat`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `acc_hi`, `acc_lo` and `done` are all zero.
- R2: `clr` set to 1 zeroes both halves at the next edge. It overrides any load or start in the same cycle.
- R3: `ld_hi` writes `ld_hi_data` into `acc_hi` and `ld_lo` writes `ld_lo_data` into `acc_lo`. A half that is not loaded keeps its value. If any load is present, a start in the same cycle is discarded.
- R4: A start that is not overridden raises `done` for exactly one cycle, in the cycle after the edge that samples it. The new accumulator value is visible in that same cycle. An overridden start leaves `done` at 0.
- R5: With `mode_word`=0 and `sat_en`=0, the result is {acc_hi,acc_lo} + sext(op_a)*sext(op_b), modulo 2^64.
- R6: With `mode_word`=1 and `sat_en`=0, the product is sext(op_a[15:0])*sext(op_b[15:0]). Bits 31:16 of the operands are ignored, and the sum wraps modulo 2^64.
- R7: With `mode_word`=0 and `sat_en`=1, take the wrapped sum S. If S is negative, `acc_hi` is S[63:32] with bits 31:16 forced to 1. Otherwise `acc_hi` is S[63:32] with bits 31:15 forced to 0. In both cases `acc_lo` is S[31:0].
- R8: With `mode_word`=1 and `sat_en`=1, a wrapped sum S below -2^31 gives acc_hi=1 and acc_lo=0x80000000. An S above 2^31-1 gives acc_hi=1 and acc_lo=0x7FFFFFFF. Any other S is stored unchanged.
- R9: In a cycle with no `clr`, no load and no start, both halves hold their value and `done` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start one accumulate |
| mode_word | input | 1 | 0: 32x32 long mode, 1: 16x16 word mode |
| sat_en | input | 1 | Enable the saturation rules |
| op_a | input | 32 | First multiplicand |
| op_b | input | 32 | Second multiplicand |
| clr | input | 1 | Zero both accumulator halves |
| ld_hi | input | 1 | Load strobe for the high half |
| ld_hi_data | input | 32 | Value for the high half |
| ld_lo | input | 1 | Load strobe for the low half |
| ld_lo_data | input | 32 | Value for the low half |
| acc_hi | output | 32 | Accumulator bits 63:32 |
| acc_lo | output | 32 | Accumulator bits 31:0 |
| done | output | 1 | One-cycle pulse: a new accumulate result is visible |

## Verification
Every result of this block is due exactly one rising edge after the strobe that causes it. This holds for the accumulate sum and its `done` pulse, for a clear and for a load, and there is no longer path. The bench therefore changes its inputs on a falling edge. It then compares both halves and `done` on the very next falling edge, half a period after the updating edge. It never samples at the edge itself. Idle and override cases are read on the same next falling edge, so a late or missing update shows up as a mismatch.

// File: rtl/mac_sat.sv
module mac_sat #(
  parameter int W = 32,
  parameter int HW = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         mode_word,
  input  logic         sat_en,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         clr,
  input  logic         ld_hi,
  input  logic [W-1:0] ld_hi_data,
  input  logic         ld_lo,
  input  logic [W-1:0] ld_lo_data,
  output logic [W-1:0] acc_hi,
  output logic [W-1:0] acc_lo,
  output logic         done
);
  localparam int AW = 2 * W;

  logic [AW-1:0] prod_l, prod_w, sum;
  logic [W-1:0]  nxt_hi, nxt_lo;
  logic          over_neg, over_pos, take;

  assign prod_l = {{W{op_a[W-1]}}, op_a} * {{W{op_b[W-1]}}, op_b};
  assign prod_w = {{(AW-HW){op_a[HW-1]}}, op_a[HW-1:0]} *
                  {{(AW-HW){op_b[HW-1]}}, op_b[HW-1:0]};
  assign sum = {acc_hi, acc_lo} + (mode_word ? prod_w : prod_l);

  // outside signed W-bit range: bits AW-1..W-1 not all equal
  assign over_neg = sum[AW-1] & ~(&sum[AW-2:W-1]);
  assign over_pos = ~sum[AW-1] & (|sum[AW-2:W-1]);

  always_comb begin
    nxt_hi = sum[AW-1:W];
    nxt_lo = sum[W-1:0];
    if (sat_en) begin
      if (!mode_word) begin
        if (sum[AW-1]) nxt_hi = sum[AW-1:W] | {{(W-HW){1'b1}}, {HW{1'b0}}};
        else           nxt_hi = sum[AW-1:W] & {{(W-HW+1){1'b0}}, {(HW-1){1'b1}}};
      end else if (over_neg) begin
        nxt_hi = W'(1);
        nxt_lo = {1'b1, {(W-1){1'b0}}};
      end else if (over_pos) begin
        nxt_hi = W'(1);
        nxt_lo = {1'b0, {(W-1){1'b1}}};
      end
    end
  end

  assign take = start & ~clr & ~ld_hi & ~ld_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_hi <= '0;
      acc_lo <= '0;
      done   <= 1'b0;
    end else begin
      done <= take;
      if (clr) begin
        acc_hi <= '0;
        acc_lo <= '0;
      end else if (ld_hi || ld_lo) begin
        if (ld_hi) acc_hi <= ld_hi_data;
        if (ld_lo) acc_lo <= ld_lo_data;
      end else if (start) begin
        acc_hi <= nxt_hi;
        acc_lo <= nxt_lo;
      end
    end
  end
endmodule

module mac_sat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        mode_word,
  input logic        sat_en,
  input logic        clr,
  input logic        ld_hi,
  input logic [31:0] ld_hi_data,
  input logic        ld_lo,
  input logic [31:0] ld_lo_data,
  input logic [31:0] acc_hi,
  input logic [31:0] acc_lo,
  input logic        done
);
  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_hi == 32'h0 && acc_lo == 32'h0));

  p_load_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && ld_hi) |=> acc_hi == $past(ld_hi_data));

  p_load_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && ld_lo) |=> acc_lo == $past(ld_lo_data));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !clr && !ld_hi && !ld_lo) |=> done);

  p_done_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (clr || ld_hi || ld_lo)) |=> !done);

  p_long_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !clr && !ld_hi && !ld_lo && !mode_word && sat_en) |=>
      (acc_hi[31] ? (acc_hi[31:16] == 16'hFFFF) : (acc_hi[31:15] == 17'h0)));

  p_word_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !clr && !ld_hi && !ld_lo && mode_word && sat_en) |=>
      ((acc_hi == 32'h1 && (acc_lo == 32'h7FFFFFFF || acc_lo == 32'h80000000)) ||
       acc_hi == {32{acc_lo[31]}}));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !clr && !ld_hi && !ld_lo) |=> ($stable(acc_hi) && $stable(acc_lo) && !done));
endmodule

bind mac_sat mac_sat_chk u_chk (.*);

// File: tb/mac_sat_test.sv
module mac_sat_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, mode_word = 0, sat_en = 0, clr = 0, ld_hi = 0, ld_lo = 0;
  logic [31:0] op_a = 0, op_b = 0, ld_hi_data = 0, ld_lo_data = 0;
  logic [31:0] acc_hi, acc_lo;
  logic done;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  mac_sat uut (.*);

  function automatic logic [31:0] val(int i);
    case (i)
      0: return 32'h0;        1: return 32'h1;        2: return 32'hFFFFFFFF;
      3: return 32'h7FFFFFFF; 4: return 32'h80000000; 5: return 32'h00008000;
      6: return 32'h00007FFF; 7: return 32'h12345678; default: return 32'hFFFF8001;
    endcase
  endfunction

  function automatic logic [63:0] preset(int i);
    case (i)
      0: return 64'h0;                  1: return 64'h0000000000000001;
      2: return 64'hFFFFFFFFFFFFFFFF;   3: return 64'h000000007FFFFFF0;
      4: return 64'hFFFFFFFF80000010;   5: return 64'h00007FFFFFFFFFFF;
      6: return 64'h7FFFFFFFFFFFFFFF;   default: return 64'hFFFF800000000000;
    endcase
  endfunction

  function automatic logic [63:0] model(logic [63:0] acc, logic [31:0] a, logic [31:0] b,
                                        logic word, logic sat);
    longint s, p;
    logic [31:0] h;
    if (word) p = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
    else      p = longint'($signed(a)) * longint'($signed(b));
    s = longint'(acc) + p;
    if (!sat) return 64'(s);
    if (!word) begin
      h = s[63:32];
      h = (s < 0) ? (h | 32'hFFFF0000) : (h & 32'h00007FFF);
      return {h, s[31:0]};
    end
    if (s < -64'sd2147483648) return {32'h1, 32'h80000000};
    if (s > 64'sd2147483647)  return {32'h1, 32'h7FFFFFFF};
    return 64'(s);
  endfunction

  task automatic check(string req, logic [31:0] eh, logic [31:0] el, logic ed);
    checks++;
    if (acc_hi !== eh || acc_lo !== el || done !== ed) begin
      fails++;
      $display("FAIL %s: got hi=%h lo=%h done=%b, want hi=%h lo=%h done=%b",
               req, acc_hi, acc_lo, done, eh, el, ed);
    end
  endtask

  task automatic load(logic [63:0] v);
    ld_hi = 1; ld_lo = 1; ld_hi_data = v[63:32]; ld_lo_data = v[31:0];
    @(negedge clk);
    ld_hi = 0; ld_lo = 0;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout, want completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [63:0] e;
    @(negedge clk);
    check("R1 in reset", 0, 0, 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", 0, 0, 0);

    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 8; p++) begin
        for (int i = 0; i < 9; i++) begin
          for (int j = 0; j < 9; j++) begin
            load(preset(p));
            mode_word = m[0]; sat_en = m[1];
            op_a = val(i); op_b = val(j);
            start = 1;
            @(negedge clk);
            start = 0;
            e = model(preset(p), val(i), val(j), m[0], m[1]);
            case (m)
              0: check("R5 long wrap R4", e[63:32], e[31:0], 1);
              1: check("R6 word wrap R4", e[63:32], e[31:0], 1);
              2: check("R7 long sat R4", e[63:32], e[31:0], 1);
              default: check("R8 word sat R4", e[63:32], e[31:0], 1);
            endcase
          end
        end
      end
    end

    // R6: upper operand bits ignored in word mode
    load(64'h0);
    mode_word = 1; sat_en = 0; op_a = 32'hABCD0003; op_b = 32'h5555FFFE; start = 1;
    @(negedge clk); start = 0;
    check("R6 high bits ignored", 32'hFFFFFFFF, 32'hFFFFFFFA, 1);

    // R9: idle holds
    repeat (3) @(negedge clk);
    check("R9 idle hold", 32'hFFFFFFFF, 32'hFFFFFFFA, 0);

    // R3: single-half load keeps the other half, start discarded
    ld_lo = 1; ld_lo_data = 32'h00000042; start = 1; op_a = 5; op_b = 7; mode_word = 0;
    @(negedge clk); ld_lo = 0; start = 0;
    check("R3 lo load beats start R4", 32'hFFFFFFFF, 32'h00000042, 0);
    ld_hi = 1; ld_hi_data = 32'h00001234;
    @(negedge clk); ld_hi = 0;
    check("R3 hi load only", 32'h00001234, 32'h00000042, 0);

    // R2: clear beats load and start
    clr = 1; ld_hi = 1; ld_lo = 1; ld_hi_data = 32'h9; ld_lo_data = 32'h9; start = 1;
    @(negedge clk); clr = 0; ld_hi = 0; ld_lo = 0; start = 0;
    check("R2 clear priority R4", 0, 0, 0);

    // R4: done is a single pulse
    op_a = 3; op_b = 4; mode_word = 0; sat_en = 0; start = 1;
    @(negedge clk); start = 0;
    check("R4 pulse", 0, 12, 1);
    @(negedge clk);
    check("R4 pulse ends R9", 0, 12, 0);

    // R1: asynchronous reset clears everything
    rst_n = 0;
    @(negedge clk);
    check("R1 reset again", 0, 0, 0);
    rst_n = 1;
    @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule